// File: doc/BRIEF.md
# Cache Flush Sequencer

This block drives a complete flush of a small write-back cache. A flush request arrives on an asynchronous input and passes through a synchronizer. A rising edge of the synchronized level, seen while the block is idle, starts a two-pass walk over every line index. The first pass reads the state of each line through the tag-state port. For each line in the modified state it raises a write-back request and holds it until a grant arrives. The second pass invalidates every line, one line per clock. When the last line is invalidated the block emits a single-cycle acknowledge.

While the synchronized request is high, or while a walk is in progress, the block tells the cache not to allocate or fill new lines. The same request pin doubles as a reset-time strap: its synchronized level on the first clock after reset release is held as a configuration bit until the next reset.

Top module: `flush_seq`

## Requirements
- R1: The request input passes through SYNC_STAGES flip-flops (default 2). A flush starts only on a 0-to-1 transition of the synchronized level seen while idle. With the defaults, `busy` rises on the third rising clock edge after the input goes high.
- R2: In the first pass, a write-back is requested for exactly the lines whose `line_state` equals 2'b11 (modified), in ascending index order. The encoding is 00 invalid, 01 shared, 10 exclusive, 11 modified. Lines in states 00, 01 and 10 cause no write-back.
- R3: `wb_req` stays high, with `line_idx` unchanged, until the clock edge at which `wb_grant` is high. The walk does not advance to the next index before that edge.
- R4: After the write-back pass, `inval_en` is raised once for each index from 0 to NLINES-1 in turn, so every line is invalid when the acknowledge appears.
- R5: `flush_ack` is high for exactly one clock, immediately after the last invalidation. `busy` is high from the first line visited until that clock, and falls at the same edge at which `flush_ack` rises.
- R6: `alloc_block` is high whenever the synchronized request is high or a walk is in progress, and low otherwise.
- R7: Request edges that arrive while a walk runs are ignored. A request still held when the acknowledge issues starts no second flush until it goes low and high again.
- R8: On the first clock after `rst` falls, the synchronized request level is captured into `strap_cfg`, which holds it until the next reset. A request held high through reset release starts no flush.
- R9: While `rst` is high, `busy`, `wb_req`, `inval_en` and `flush_ack` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_req | input | 1 | Asynchronous flush request, active high |
| line_state | input | 2 | State of the line at `line_idx`, returned by the cache array in the same cycle |
| wb_grant | input | 1 | Write-back accepted for the line at `line_idx` |
| line_idx | output | IDX_W | Line index presented to the cache array |
| inval_en | output | 1 | Invalidate the line at `line_idx` on this clock |
| wb_req | output | 1 | Write back the line at `line_idx` |
| alloc_block | output | 1 | Suppress new allocations and fills |
| busy | output | 1 | Flush walk in progress |
| flush_ack | output | 1 | One-cycle flush-complete pulse |
| strap_cfg | output | 1 | Request level captured at reset release |

## Verification
The walk is exercised with a mixed pattern of all four line states, with every line modified, and with no line modified. These patterns separate a correct state decode from one that also writes back exclusive lines or that misses the first and last index. Grant latency is varied between zero and several cycles, which shows whether the walk ever advances before a grant. A request toggled during a walk, and a request held past the acknowledge, show whether edge qualification is correct. Resets with the pin held high and held low show the strap capture, and show that a held pin does not start a flush on its own.

// File: rtl/flush_pkg.sv
package flush_pkg;
  typedef enum logic [1:0] {
    LS_INV = 2'b00,
    LS_SHR = 2'b01,
    LS_EXC = 2'b10,
    LS_MOD = 2'b11
  } line_st_e;

  typedef enum logic [2:0] {
    W_IDLE,
    W_SCAN,
    W_WAIT,
    W_INVAL
  } walk_st_e;
endpackage

// File: rtl/flush_sync.sv
module flush_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_async,
  output logic req_lvl,
  output logic req_rise,
  output logic strap
);
  localparam int TOP = STAGES - 1;

  // The chain is deliberately left out of reset so the strap sees the pin during reset.
  logic [TOP:0] chain = '0;
  logic         prev  = 1'b0;
  logic         rst_d = 1'b1;
  logic         strap_q = 1'b0;

  always_ff @(posedge clk) begin
    chain <= {chain[TOP-1:0], req_async};
    prev  <= chain[TOP];
    rst_d <= rst;
    if (rst_d && !rst)
      strap_q <= chain[TOP];
  end

  assign req_lvl  = chain[TOP];
  assign req_rise = chain[TOP] & ~prev;
  assign strap    = strap_q;
endmodule

// File: rtl/flush_walker.sv
module flush_walker
  import flush_pkg::*;
#(
  parameter int NLINES = 8,
  parameter int IDX_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [1:0]       line_state,
  input  logic             wb_grant,
  output logic [IDX_W-1:0] line_idx,
  output logic             wb_req,
  output logic             inval_en,
  output logic             busy,
  output logic             flush_ack
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NLINES - 1);

  walk_st_e         st;
  logic [IDX_W-1:0] idx;
  logic             at_last;

  assign at_last = (idx == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= W_IDLE;
      idx       <= '0;
      wb_req    <= 1'b0;
      inval_en  <= 1'b0;
      busy      <= 1'b0;
      flush_ack <= 1'b0;
    end else begin
      flush_ack <= 1'b0;
      unique case (st)
        W_IDLE: begin
          if (start) begin
            idx  <= '0;
            busy <= 1'b1;
            st   <= W_SCAN;
          end
        end
        W_SCAN: begin
          if (line_st_e'(line_state) == LS_MOD) begin
            wb_req <= 1'b1;
            st     <= W_WAIT;
          end else if (at_last) begin
            idx      <= '0;
            inval_en <= 1'b1;
            st       <= W_INVAL;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        W_WAIT: begin
          if (wb_grant) begin
            wb_req <= 1'b0;
            if (at_last) begin
              idx      <= '0;
              inval_en <= 1'b1;
              st       <= W_INVAL;
            end else begin
              idx <= idx + 1'b1;
              st  <= W_SCAN;
            end
          end
        end
        W_INVAL: begin
          if (at_last) begin
            inval_en  <= 1'b0;
            busy      <= 1'b0;
            flush_ack <= 1'b1;
            st        <= W_IDLE;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: st <= W_IDLE;
      endcase
    end
  end

  assign line_idx = idx;
endmodule

// File: rtl/flush_seq.sv
module flush_seq #(
  parameter int NLINES      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int IDX_W       = $clog2(NLINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush_req,
  input  logic [1:0]       line_state,
  input  logic             wb_grant,
  output logic [IDX_W-1:0] line_idx,
  output logic             inval_en,
  output logic             wb_req,
  output logic             alloc_block,
  output logic             busy,
  output logic             flush_ack,
  output logic             strap_cfg
);
  logic req_lvl, req_rise, start;

  flush_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .req_async (flush_req),
    .req_lvl   (req_lvl),
    .req_rise  (req_rise),
    .strap     (strap_cfg)
  );

  assign start = req_rise & ~rst;

  flush_walker #(.NLINES(NLINES), .IDX_W(IDX_W)) u_walk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .line_state (line_state),
    .wb_grant   (wb_grant),
    .line_idx   (line_idx),
    .wb_req     (wb_req),
    .inval_en   (inval_en),
    .busy       (busy),
    .flush_ack  (flush_ack)
  );

  assign alloc_block = req_lvl | busy;
endmodule

// File: rtl/flush_seq_chk.sv
module flush_seq_chk #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       line_state,
  input logic             wb_grant,
  input logic [IDX_W-1:0] line_idx,
  input logic             inval_en,
  input logic             wb_req,
  input logic             alloc_block,
  input logic             busy,
  input logic             flush_ack
);
  a_r5_ack_single: assert property (@(posedge clk) disable iff (rst)
    flush_ack |=> !flush_ack);

  a_r5_busy_ends_at_ack: assert property (@(posedge clk) disable iff (rst)
    flush_ack |-> (!busy && $past(busy)));

  a_r3_hold_until_grant: assert property (@(posedge clk) disable iff (rst)
    (wb_req && !wb_grant) |=> (wb_req && $stable(line_idx)));

  a_r2_wb_only_modified: assert property (@(posedge clk) disable iff (rst)
    wb_req |-> (line_state == 2'b11));

  a_r4_inval_in_walk: assert property (@(posedge clk) disable iff (rst)
    inval_en |-> (busy && !wb_req));

  a_r6_block_while_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> alloc_block);

  a_r9_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!busy && !wb_req && !inval_en && !flush_ack));
endmodule

bind flush_seq flush_seq_chk #(.IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .line_state  (line_state),
  .wb_grant    (wb_grant),
  .line_idx    (line_idx),
  .inval_en    (inval_en),
  .wb_req      (wb_req),
  .alloc_block (alloc_block),
  .busy        (busy),
  .flush_ack   (flush_ack)
);

// File: tb/tb_flush_seq.sv
module tb_flush_seq;
  localparam int NL = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          flush_req = 1'b0;
  logic          wb_grant = 1'b0;
  logic [1:0]    line_state;
  logic [IW-1:0] line_idx;
  logic          inval_en, wb_req, alloc_block, busy, flush_ack, strap_cfg;

  logic [1:0] mem [NL];
  int exp_q[$];
  int checks = 0, errors = 0;
  int gdelay = 0, wait_cnt = 0;
  int ack_cnt = 0, busy_rises = 0;
  logic ack_prev = 1'b0, busy_prev = 1'b0;
  int cyc = 0;

  always #2 clk = ~clk;

  flush_seq #(.NLINES(NL), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .flush_req(flush_req), .line_state(line_state),
    .wb_grant(wb_grant), .line_idx(line_idx), .inval_en(inval_en),
    .wb_req(wb_req), .alloc_block(alloc_block), .busy(busy),
    .flush_ack(flush_ack), .strap_cfg(strap_cfg)
  );

  assign line_state = mem[line_idx];

  // Cache array model
  always @(posedge clk) if (inval_en) mem[line_idx] <= 2'b00;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: grants write-backs and scores them against the queue
  always @(negedge clk) begin
    if (wb_grant) wb_grant = 1'b0;
    else if (wb_req) begin
      if (wait_cnt >= gdelay) begin
        wb_grant = 1'b1;
        wait_cnt = 0;
        if (exp_q.size() == 0) check(1'b0, "R2 unexpected write-back", int'(line_idx), -1);
        else begin
          int e;
          e = exp_q.pop_front();
          check(int'(line_idx) == e, "R2 write-back index", int'(line_idx), e);
        end
      end else wait_cnt++;
    end
  end

  always @(negedge clk) begin
    if (flush_ack) begin
      ack_cnt++;
      check(!ack_prev, "R5 ack width", 2, 1);
      check(!busy, "R5 busy at ack", int'(busy), 0);
    end
    if (busy && !busy_prev) busy_rises++;
    ack_prev  = flush_ack;
    busy_prev = busy;
  end

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic load(input logic [1:0] p [NL]);
    for (int i = 0; i < NL; i++) begin
      mem[i] = p[i];
      if (p[i] == 2'b11) exp_q.push_back(i);
    end
  endtask

  task automatic run_flush(input logic [1:0] p [NL], input int gd);
    int n;
    gdelay = gd;
    load(p);
    @(negedge clk) flush_req = 1'b1;
    @(negedge clk) check(!busy, "R1 sync stage 1", int'(busy), 0);
    @(negedge clk) check(!busy, "R1 sync stage 2", int'(busy), 0);
    check(alloc_block, "R6 block on request", int'(alloc_block), 1);
    @(negedge clk) check(busy, "R1 busy after sync", int'(busy), 1);
    n = 0;
    while (!flush_ack && n < 500) begin @(negedge clk); n++; end
    check(flush_ack, "R5 ack seen", int'(flush_ack), 1);
    check(exp_q.size() == 0, "R2 all write-backs issued", exp_q.size(), 0);
    for (int i = 0; i < NL; i++)
      check(mem[i] == 2'b00, "R4 line invalid", int'(mem[i]), 0);
    flush_req = 1'b0;
    @(negedge clk); @(negedge clk); @(negedge clk);
    check(!alloc_block, "R6 block released", int'(alloc_block), 0);
    exp_q.delete();
  endtask

  initial begin
    logic [1:0] pa [NL] = '{2'b11, 2'b00, 2'b01, 2'b11, 2'b10, 2'b11, 2'b00, 2'b01};
    logic [1:0] pb [NL] = '{default: 2'b11};
    logic [1:0] pc [NL] = '{2'b10, 2'b01, 2'b10, 2'b00, 2'b01, 2'b10, 2'b01, 2'b10};
    int acks0, rises0;
    for (int i = 0; i < NL; i++) mem[i] = 2'b00;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); @(negedge clk);
    check(!busy && !wb_req && !inval_en && !flush_ack, "R9 reset state", int'(busy), 0);
    check(!strap_cfg, "R8 strap low", int'(strap_cfg), 0);
    check(!alloc_block, "R6 idle no block", int'(alloc_block), 0);

    run_flush(pa, 0);
    run_flush(pb, 3);
    run_flush(pc, 1);
    check(ack_cnt == 3, "R5 ack count", ack_cnt, 3);

    // R7: toggle during walk, then hold past ack
    gdelay = 4;
    load(pb);
    acks0 = ack_cnt; rises0 = busy_rises;
    @(negedge clk) flush_req = 1'b1;
    repeat (8) @(negedge clk);
    flush_req = 1'b0;
    repeat (4) @(negedge clk);
    flush_req = 1'b1;
    while (!flush_ack) @(negedge clk);
    repeat (30) @(negedge clk);
    check(busy_rises - rises0 == 1, "R7 one walk only", busy_rises - rises0, 1);
    check(ack_cnt - acks0 == 1, "R7 one ack only", ack_cnt - acks0, 1);
    check(alloc_block, "R6 held request blocks", int'(alloc_block), 1);
    exp_q.delete();

    // R8: strap high through reset
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (6) @(negedge clk);
    check(strap_cfg, "R8 strap captured high", int'(strap_cfg), 1);
    check(!busy, "R8 held pin starts no flush", int'(busy), 0);
    flush_req = 1'b0;
    repeat (4) @(negedge clk);
    check(strap_cfg, "R8 strap held", int'(strap_cfg), 1);
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(!strap_cfg, "R8 strap captured low", int'(strap_cfg), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule